// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast oscillator clock by a programmable ratio for the feedback path of a frequency synthesizer. A behavioural prescaler divides the oscillator clock by 16 or by 17. A modulus-control signal picks the ratio. Two counters step once per prescaler cycle. The swallow counter keeps the prescaler at 17 while its count is nonzero. The main down-counter sets how many prescaler cycles make up one output period. The ratio from one output pulse to the next is therefore 16·N + A oscillator cycles.

When the main counter reaches its terminal count, the block emits a one-cycle carry pulse. This pulse goes to the phase detector's feedback input. The same event reloads both counters from the programmed values. The programmed values are sampled only at that reload, so software can rewrite them at any time without disturbing the period in progress. A swallow value that is not below the main value would make the ratio meaningless. The block then clamps the swallow count and raises an error flag for that period.

Top module: `pulse_swallow_div`

## Requirements
- R1: The number of oscillator cycles from one carry pulse to the next equals 16·N + A, with N the applied main value and A the applied swallow value.
- R2: The modulus-control output is high exactly while the swallow count is nonzero. Each output period it is high for 17·A oscillator cycles, starting in the cycle in which the carry pulse is high.
- R3: The carry output is high for exactly one oscillator cycle per output period.
- R4: The programmed A and N inputs are sampled only in the cycle where the main counter reloads. A change during a period leaves that period's length unchanged and takes effect from the next period.
- R5: When the programmed A is greater than or equal to the programmed N, the applied A is N−1. A programmed N of 0 is applied as 1 with A forced to 0. In both cases the error flag is set.
- R6: The error flag changes only at a reload. It stays high for the whole period that uses a clamped setting and is low for every period whose setting is legal.
- R7: While reset is held low, the carry, modulus-control and error outputs are 0. After reset is released, the counters start at terminal count with no swallow. The first carry pulse therefore follows exactly 16 oscillator cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock being divided |
| rstN | input | 1 | Active-low synchronous reset |
| aProg | input | 4 | Programmed swallow value |
| nProg | input | 12 | Programmed main-counter value |
| modCtl | output | 1 | Prescaler modulus select, 1 = divide by 17 |
| carryOut | output | 1 | One-cycle feedback pulse, marks each reload |
| progErr | output | 1 | Set for a period whose setting was clamped |

## Verification
The bench rewrites the programmed values partway through every output period. A design that sampled its inputs continuously would then show the new ratio one period early. The settings include A = 0, A = 15 with the smallest legal N, and the largest N. An off-by-one in the terminal count or in the swallow stop point would show up as a ratio wrong by 1, 16 or 17. A setting with A above N, and a setting with N = 0, check the clamp and the error flag; an unclamped design would produce a period that is too long. These are followed by a legal setting, which catches a flag that never clears. The bench also counts the cycles in which the modulus control is high, which exposes a prescaler that stays at 17 for one cycle too many or too few.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;

  // Strobes from the prescaler control to the counter datapath.
  // advance: one prescaler cycle ended, main count not terminal.
  // reload : one prescaler cycle ended at terminal main count.
  typedef struct packed {
    logic advance;
    logic reload;
  } divStrobe_t;

endpackage

// File: rtl/swallow_div_ctrl.sv
module swallow_div_ctrl
  import swallow_div_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modCtl,
  input  logic       nTerm,
  output divStrobe_t strb
);

  localparam int PCNT_W = PRE_W + 1;
  localparam logic [PCNT_W-1:0] LAST_LO = PCNT_W'((2 ** PRE_W) - 1);
  localparam logic [PCNT_W-1:0] LAST_HI = PCNT_W'(2 ** PRE_W);

  logic [PCNT_W-1:0] pCnt;
  logic [PCNT_W-1:0] pLast;
  logic              preTick;

  // Behavioural prescaler: the count runs 0..P-1 or 0..P.
  // modCtl only changes on a tick, so it is steady within a prescaler cycle.
  assign pLast   = modCtl ? LAST_HI : LAST_LO;
  assign preTick = (pCnt == pLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pCnt <= '0;
    end else if (preTick) begin
      pCnt <= '0;
    end else begin
      pCnt <= pCnt + 1'b1;
    end
  end

  always_comb begin
    strb.advance = preTick & ~nTerm;
    strb.reload  = preTick &  nTerm;
  end

  // The prescaler never runs past the long modulus.
  p_presc_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    pCnt <= LAST_HI);

  // The extra (17th) cycle is only reached while swallowing.
  p_long_only_swallow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pCnt == LAST_HI) |-> modCtl);

endmodule

// File: rtl/swallow_div_dp.sv
module swallow_div_dp
  import swallow_div_pkg::*;
#(
  parameter int A_W = 4,
  parameter int N_W = 12
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [A_W-1:0] aProg,
  input  logic [N_W-1:0] nProg,
  input  divStrobe_t     strb,
  output logic           modCtl,
  output logic           nTerm,
  output logic           carryOut,
  output logic           progErr
);

  logic [A_W-1:0] aCnt;
  logic [N_W-1:0] nCnt;
  logic [A_W-1:0] aLoad;
  logic [N_W-1:0] nLoad;
  logic [N_W-1:0] aWide;
  logic           errLoad;

  // Clamp the programmed pair so that swallow stays below main.
  always_comb begin
    aWide   = N_W'(aProg);
    errLoad = (aWide >= nProg);
    nLoad   = (nProg == '0) ? N_W'(1) : nProg;
    aLoad   = errLoad ? A_W'(nLoad - 1'b1) : aProg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aCnt     <= '0;
      nCnt     <= N_W'(1);
      carryOut <= 1'b0;
      progErr  <= 1'b0;
    end else begin
      carryOut <= strb.reload;
      if (strb.reload) begin
        aCnt    <= aLoad;
        nCnt    <= nLoad;
        progErr <= errLoad;
      end else if (strb.advance) begin
        nCnt <= nCnt - 1'b1;
        if (aCnt != '0) begin
          aCnt <= aCnt - 1'b1;
        end
      end
    end
  end

  assign modCtl = (aCnt != '0);
  assign nTerm  = (nCnt == N_W'(1));

  p_carry_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    carryOut |=> !carryOut);

  p_main_nonzero_r1: assert property (@(posedge clk) disable iff (!rstN)
    nCnt != '0);

  p_swallow_below_main_r5: assert property (@(posedge clk) disable iff (!rstN)
    N_W'(aCnt) < nCnt);

  p_err_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.reload |=> $stable(progErr));

  p_mod_drop_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(modCtl) |-> $past(strb.advance));

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import swallow_div_pkg::*;
#(
  parameter int PRE_W = 4,
  parameter int A_W   = 4,
  parameter int N_W   = 12
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [A_W-1:0] aProg,
  input  logic [N_W-1:0] nProg,
  output logic           modCtl,
  output logic           carryOut,
  output logic           progErr
);

  divStrobe_t strb;
  logic       nTerm;

  swallow_div_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .modCtl (modCtl),
    .nTerm  (nTerm),
    .strb   (strb)
  );

  swallow_div_dp #(.A_W(A_W), .N_W(N_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .aProg    (aProg),
    .nProg    (nProg),
    .strb     (strb),
    .modCtl   (modCtl),
    .nTerm    (nTerm),
    .carryOut (carryOut),
    .progErr  (progErr)
  );

endmodule

// File: tb/sim_pulse_swallow_div.sv
module sim_pulse_swallow_div;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  aProg;
  logic [11:0] nProg;
  logic        modCtl, carryOut, progErr;

  always #5 clk = ~clk;

  pulse_swallow_div u0 (
    .clk(clk), .rstN(rstN), .aProg(aProg), .nProg(nProg),
    .modCtl(modCtl), .carryOut(carryOut), .progErr(progErr)
  );

  typedef struct {
    int ratio;
    int modCyc;
    bit err;
  } expItem_t;

  expItem_t expQ[$];
  int  total = 0;
  int  bad = 0;
  int  cyc = 0;
  int  lastCarry = 0;
  int  modCount = 0;
  bit  seenFirst = 0;
  bit  prevCarry = 0;
  bit  errAtStart = 0;
  bit  done = 0;
  event carryEv;

  localparam int NSET = 16;
  int nList[NSET] = '{100, 16, 16, 4095, 5, 0, 200, 33, 0, 0, 0, 0, 0, 0, 0, 0};
  int aList[NSET] = '{7, 0, 15, 15, 9, 3, 0, 12, 0, 0, 0, 0, 0, 0, 0, 0};

  // Expected behaviour straight from the requirements.
  function automatic expItem_t model(int n, int a);
    expItem_t e;
    int ne, ae;
    ne    = (n == 0) ? 1 : n;
    e.err = (a >= n);
    ae    = e.err ? ne - 1 : a;
    e.ratio  = 16 * ne + ae;
    e.modCyc = 17 * ae;
    return e;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (rstN && !done) begin
      expItem_t e;
      cyc++;
      if (prevCarry) check(carryOut == 1'b0, "R3 carry width", int'(carryOut), 0);
      if (carryOut) begin
        if (!seenFirst) begin
          check(cyc == 16, "R7 first carry", cyc, 16);
          seenFirst = 1;
        end else if (expQ.size() == 0) begin
          check(1'b0, "R1 unexpected carry", cyc, 0);
        end else begin
          e = expQ.pop_front();
          check(cyc - lastCarry == e.ratio, "R1 R4 period", cyc - lastCarry, e.ratio);
          check(modCount == e.modCyc, "R2 modulus cycles", modCount, e.modCyc);
          check(errAtStart == e.err, "R5 R6 error flag", int'(errAtStart), int'(e.err));
        end
        lastCarry  = cyc;
        modCount   = 0;
        errAtStart = progErr;
        -> carryEv;
      end
      if (modCtl) modCount++;
      prevCarry = carryOut;
    end
  end

  // Driver.
  initial begin
    for (int k = 8; k < NSET; k++) begin
      nList[k] = $urandom_range(400, 16);
      aList[k] = $urandom_range(15, 0);
    end
    nProg = 12'(nList[0]);
    aProg = 4'(aList[0]);
    repeat (3) @(negedge clk);
    check(carryOut == 1'b0, "R7 reset carry", int'(carryOut), 0);
    check(modCtl == 1'b0, "R7 reset modCtl", int'(modCtl), 0);
    check(progErr == 1'b0, "R7 reset progErr", int'(progErr), 0);
    @(negedge clk) rstN <= 1'b1;
    for (int k = 0; k < NSET; k++) begin
      @(carryEv);
      expQ.push_back(model(int'(nProg), int'(aProg)));
      if (k < NSET - 1) begin
        // Rewrite mid-period: must not affect the running period (R4).
        repeat (1 + k % 8) @(negedge clk);
        nProg = 12'(nList[k + 1]);
        aProg = 4'(aList[k + 1]);
      end
    end
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // Watchdog.
  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", expQ.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule